// File: doc/BRIEF.md
# Modulo-Reload Timer with Overflow Flag

This block is a 16-bit up-counting timer behind a small 32-bit register port. Its count source can be switched off, run from the system clock, or follow one of two single-cycle tick inputs. The chosen source then passes through a power-of-two prescaler. The counter climbs until it matches a programmable modulus. On the next prescaled tick it loads a programmable starting value instead of incrementing. That same transition raises an overflow flag, and the flag can drive an interrupt line.

Software arms an alarm of N ticks in a fixed order. It stops the counter, loads the starting value and a modulus of start + N - 1, writes the count register to reload it, and then selects a source. The flag has a two-step clear: software must first see it set on a read and then write it as zero. A new overflow that lands on the clearing write keeps the flag set.

Top module: `mod_reload_timer`

## Requirements
- R1: After reset every register reads as zero, the counter is stopped and `irq` is low.
- R2: Byte offsets are 0x00 for control/status, 0x04 for count, 0x08 for modulus and 0x4C for start value. Other offsets read zero. In control/status, bits [2:0] hold the prescale exponent, bits [4:3] the source select, bit 6 the interrupt enable and bit 7 the overflow flag. Count and start value read back in bits [15:0].
- R3: Source select 0 holds the counter still. Select 1 counts on every clock. Select 2 counts on each cycle where `fixed_tick` is high. Select 3 counts on each cycle where `ext_tick` is high.
- R4: The counter advances once per 2^P source ticks, where P is the prescale exponent. Any write to control/status restarts the prescaler phase. So with select 1, the counter's first advance comes 2^P clocks after that write.
- R5: While the count differs from the modulus, a prescaled tick adds one. When the count equals the modulus, the tick loads the start value instead and sets the overflow flag. One period is therefore (modulus - start + 1) ticks.
- R6: A write to the count register loads the start value into the counter. The written data has no effect.
- R7: Only bits [15:0] of the modulus take part in the comparison. All 32 bits read back.
- R8: `irq` is high exactly while both the overflow flag and the interrupt enable are 1.
- R9: Writing 0 to bit 7 clears the flag only if a read of control/status has returned the flag as 1 since the last write that carried bit 7 = 0. Writing 1 to bit 7 never changes the flag.
- R10: If an overflow and an accepted clear fall on the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fixed_tick | input | 1 | Tick strobe from the fixed-frequency domain (source select 2) |
| ext_tick | input | 1 | External tick strobe (source select 3) |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (arms the flag clear) |
| bus_addr | input | 7 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Overflow interrupt |

## Verification
The assertions check several rules on every cycle. A stopped source freezes the count. A count write reloads the start value. A terminal tick both reloads and sets the flag. The flag never falls without an armed clear, and it never rises without an overflow. A clear that collides with an overflow loses. With the enable low, the interrupt stays quiet. Other properties depend on the register protocol and on counts spread across many ticks, so only the bench scenarios can show them. These are the period length for each prescale and start/modulus pair, the modulus upper bits being ignored, the rule that a clear write has no effect before a read, and the ticking from each source.

// File: rtl/mrt_pkg.sv
package mrt_pkg;
  localparam int unsigned OFS_CTRL  = 'h00;
  localparam int unsigned OFS_COUNT = 'h04;
  localparam int unsigned OFS_LIMIT = 'h08;
  localparam int unsigned OFS_START = 'h4C;

  localparam int unsigned BIT_SEL_LO = 3;
  localparam int unsigned BIT_SEL_HI = 4;
  localparam int unsigned BIT_IRQ_EN = 6;
  localparam int unsigned BIT_FLAG   = 7;

  typedef enum logic [1:0] {
    SRC_OFF   = 2'd0,
    SRC_SYS   = 2'd1,
    SRC_FIXED = 2'd2,
    SRC_EXT   = 2'd3
  } src_sel_e;
endpackage

// File: rtl/mrt_prescaler.sv
module mrt_prescaler #(
  parameter int unsigned PS_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            src_tick,
  input  logic            restart,
  input  logic [PS_W-1:0] exp_sel,
  output logic            tick
);
  localparam int unsigned DIV_W = (1 << PS_W) - 1;

  logic [DIV_W-1:0] phase_q, phase_d, mask;

  always_comb begin
    for (int i = 0; i < DIV_W; i++) mask[i] = (i < int'(exp_sel));
  end

  assign tick = src_tick && ((phase_q & mask) == mask);

  always_comb begin
    phase_d = phase_q;
    if (restart)       phase_d = '0;
    else if (src_tick) phase_d = phase_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_d;
  end
endmodule

// File: rtl/mrt_counter.sv
module mrt_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] start_val,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] count,
  output logic             wrap
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign wrap  = tick && !load && (cnt_q == limit);
  assign count = cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    if (load || wrap) cnt_d = start_val;
    else if (tick)    cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/mrt_flag.sv
module mrt_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr_wr,
  input  logic rd_seen,
  output logic flag,
  output logic armed
);
  logic flag_q, flag_d, armed_q, armed_d;

  always_comb begin
    flag_d = flag_q;
    if (set_evt)               flag_d = 1'b1;
    else if (clr_wr && armed_q) flag_d = 1'b0;
  end

  always_comb begin
    armed_d = armed_q;
    if (clr_wr)                 armed_d = 1'b0;
    else if (rd_seen && flag_q) armed_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      flag_q  <= flag_d;
      armed_q <= armed_d;
    end
  end

  assign flag  = flag_q;
  assign armed = armed_q;
endmodule

// File: rtl/mod_reload_timer.sv
module mod_reload_timer
  import mrt_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned PS_W   = 3,
  parameter int unsigned ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fixed_tick,
  input  logic              ext_tick,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  logic hit_ctrl, hit_count, hit_limit, hit_start;
  assign hit_ctrl  = (bus_addr == ADDR_W'(OFS_CTRL));
  assign hit_count = (bus_addr == ADDR_W'(OFS_COUNT));
  assign hit_limit = (bus_addr == ADDR_W'(OFS_LIMIT));
  assign hit_start = (bus_addr == ADDR_W'(OFS_START));

  logic ctrl_wr, cnt_wr, clr_wr, rd_seen;
  assign ctrl_wr = bus_wr && hit_ctrl;
  assign cnt_wr  = bus_wr && hit_count;
  assign clr_wr  = ctrl_wr && !bus_wdata[BIT_FLAG];
  assign rd_seen = bus_rd && hit_ctrl;

  // configuration registers
  logic [PS_W-1:0]   exp_q, exp_d;
  src_sel_e          sel_q, sel_d;
  logic              irq_en_q, irq_en_d;
  logic [DATA_W-1:0] limit_q, limit_d;
  logic [CNT_W-1:0]  start_q, start_d;

  always_comb begin
    exp_d    = exp_q;
    sel_d    = sel_q;
    irq_en_d = irq_en_q;
    limit_d  = limit_q;
    start_d  = start_q;
    if (ctrl_wr) begin
      exp_d    = bus_wdata[PS_W-1:0];
      sel_d    = src_sel_e'(bus_wdata[BIT_SEL_HI:BIT_SEL_LO]);
      irq_en_d = bus_wdata[BIT_IRQ_EN];
    end
    if (bus_wr && hit_limit) limit_d = bus_wdata;
    if (bus_wr && hit_start) start_d = bus_wdata[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_q    <= '0;
      sel_q    <= SRC_OFF;
      irq_en_q <= 1'b0;
      limit_q  <= '0;
      start_q  <= '0;
    end else begin
      exp_q    <= exp_d;
      sel_q    <= sel_d;
      irq_en_q <= irq_en_d;
      limit_q  <= limit_d;
      start_q  <= start_d;
    end
  end

  // source select
  logic src_tick;
  always_comb begin
    unique case (sel_q)
      SRC_SYS:   src_tick = 1'b1;
      SRC_FIXED: src_tick = fixed_tick;
      SRC_EXT:   src_tick = ext_tick;
      default:   src_tick = 1'b0;
    endcase
  end

  logic cnt_tick;
  mrt_prescaler #(.PS_W(PS_W)) u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_tick (src_tick),
    .restart  (ctrl_wr),
    .exp_sel  (exp_q),
    .tick     (cnt_tick)
  );

  logic [CNT_W-1:0] limit_lo, cnt_val;
  logic             ovf;
  assign limit_lo = limit_q[CNT_W-1:0];

  mrt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (cnt_tick),
    .load      (cnt_wr),
    .start_val (start_q),
    .limit     (limit_lo),
    .count     (cnt_val),
    .wrap      (ovf)
  );

  logic flag, armed;
  mrt_flag u_flag (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_evt (ovf),
    .clr_wr  (clr_wr),
    .rd_seen (rd_seen),
    .flag    (flag),
    .armed   (armed)
  );

  assign irq = flag && irq_en_q;

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (hit_ctrl) begin
      bus_rdata[PS_W-1:0]              = exp_q;
      bus_rdata[BIT_SEL_HI:BIT_SEL_LO] = sel_q;
      bus_rdata[BIT_IRQ_EN]            = irq_en_q;
      bus_rdata[BIT_FLAG]              = flag;
    end else if (hit_count) begin
      bus_rdata[CNT_W-1:0] = cnt_val;
    end else if (hit_limit) begin
      bus_rdata = limit_q;
    end else if (hit_start) begin
      bus_rdata[CNT_W-1:0] = start_q;
    end
  end
endmodule

// File: rtl/mrt_checker.sv
module mrt_checker #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       sel,
  input logic             irq_en,
  input logic             irq,
  input logic             cnt_tick,
  input logic             cnt_wr,
  input logic             clr_wr,
  input logic             ovf,
  input logic             flag,
  input logic             armed,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] limit_lo,
  input logic [CNT_W-1:0] start_val
);
  // R3
  stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 2'd0 && !cnt_wr) |=> $stable(cnt));

  // R6
  count_write_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> (cnt == $past(start_val)));

  // R5
  terminal_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_tick && !cnt_wr && cnt == limit_lo) |=> (cnt == $past(start_val)) && flag);

  // R5
  flag_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(ovf));

  // R9
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag) |-> $past(clr_wr && armed));

  // R10
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && clr_wr) |=> flag);

  // R8
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq);
endmodule

bind mod_reload_timer mrt_checker #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sel       (sel_q),
  .irq_en    (irq_en_q),
  .irq       (irq),
  .cnt_tick  (cnt_tick),
  .cnt_wr    (cnt_wr),
  .clr_wr    (clr_wr),
  .ovf       (ovf),
  .flag      (flag),
  .armed     (armed),
  .cnt       (cnt_val),
  .limit_lo  (limit_lo),
  .start_val (start_q)
);

// File: tb/mod_reload_timer_test.sv
module mod_reload_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fixed_tick = 1'b0;
  logic        ext_tick = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [6:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #2.5 clk = ~clk;

  mod_reload_timer uut (
    .clk(clk), .rst_n(rst_n), .fixed_tick(fixed_tick), .ext_tick(ext_tick),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  localparam logic [6:0] A_CTRL = 7'h00, A_CNT = 7'h04, A_LIM = 7'h08, A_START = 7'h4C;

  typedef struct packed {
    logic [15:0] start;
    logic [31:0] limit;
    logic [2:0]  pexp;
    logic [15:0] period;
  } vec_t;

  // period = 2^pexp * (limit[15:0] - start + 1) clocks (R4, R5, R7)
  localparam vec_t VECS [0:6] = '{
    '{16'd0,   32'd0,        3'd0, 16'd1},
    '{16'd0,   32'd4,        3'd0, 16'd5},
    '{16'd10,  32'd12,       3'd2, 16'd12},
    '{16'd3,   32'd3,        3'd1, 16'd2},
    '{16'd0,   32'd9,        3'd3, 16'd80},
    '{16'd100, 32'd103,      3'd7, 16'd512},
    '{16'd0,   32'h0001_0003, 3'd0, 16'd4}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // all tasks are entered at a falling edge and return at a falling edge
  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic quiesce();
    logic [31:0] d;
    wr(A_CTRL, 32'h0);
    rd(A_CTRL, d);
    wr(A_CTRL, 32'h0);
  endtask

  task automatic pulse_fixed();
    fixed_tick = 1'b1; @(negedge clk); fixed_tick = 1'b0;
  endtask

  task automatic pulse_ext();
    ext_tick = 1'b1; @(negedge clk); ext_tick = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int found;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state, R2 offsets
    rd(A_CTRL, d);  check("R1 ctrl", d, 32'h0);
    rd(A_CNT, d);   check("R1 count", d, 32'h0);
    rd(A_LIM, d);   check("R1 limit", d, 32'h0);
    rd(A_START, d); check("R1 start", d, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);

    // R2 field placement and unmapped offset
    wr(A_CTRL, 32'h0000_005D);
    rd(A_CTRL, d);  check("R2 ctrl fields", d, 32'h0000_005D);
    wr(A_START, 32'hABCD_1234);
    rd(A_START, d); check("R2 start width", d, 32'h0000_1234);
    rd(7'h10, d);   check("R2 unmapped", d, 32'h0);
    quiesce();

    // R4 R5 R7 vector table
    foreach (VECS[k]) begin
      quiesce();
      wr(A_START, {16'h0, VECS[k].start});
      wr(A_LIM, VECS[k].limit);
      rd(A_LIM, d); check("R7 limit readback", d, VECS[k].limit);
      wr(A_CNT, 32'h0);
      wr(A_CTRL, {24'h0, 3'b000, 2'd1, VECS[k].pexp});
      found = -1;
      for (int n = 0; n < int'(VECS[k].period) + 20; n++) begin
        rd(A_CTRL, d);
        if (d[7]) begin found = n; break; end
      end
      check("R5 period", found, {16'h0, VECS[k].period});
    end
    quiesce();

    // R6 count write loads start, data ignored
    wr(A_START, 32'h0000_1234);
    wr(A_CNT, 32'h0000_FFFF);
    rd(A_CNT, d); check("R6 count reload", d, 32'h0000_1234);

    // R3 stopped source holds the count
    idle(10);
    rd(A_CNT, d); check("R3 stopped", d, 32'h0000_1234);

    // R3 R5 external tick, step by step
    wr(A_START, 32'd5); wr(A_LIM, 32'd7); wr(A_CNT, 32'd0);
    wr(A_CTRL, 32'h0000_0018);
    idle(3);
    rd(A_CNT, d); check("R3 ext idle", d, 32'd5);
    pulse_ext(); rd(A_CNT, d); check("R3 ext tick", d, 32'd6);
    pulse_ext(); rd(A_CNT, d); check("R5 at limit", d, 32'd7);
    rd(A_CTRL, d); check("R5 no flag at limit", d, 32'h0000_0018);
    pulse_ext(); rd(A_CNT, d); check("R5 reload to start", d, 32'd5);
    rd(A_CTRL, d); check("R5 flag on reload", d, 32'h0000_0098);
    quiesce();

    // R3 R4 fixed tick with divide by 2: three counts need six strobes
    wr(A_START, 32'd0); wr(A_LIM, 32'd2); wr(A_CNT, 32'd0);
    wr(A_CTRL, 32'h0000_0011);
    for (int i = 0; i < 5; i++) pulse_fixed();
    rd(A_CTRL, d); check("R4 fixed five strobes", d, 32'h0000_0011);
    pulse_fixed();
    rd(A_CTRL, d); check("R3 fixed six strobes", d, 32'h0000_0091);
    quiesce();

    // R8 R9 interrupt and two-step clear
    wr(A_START, 32'd0); wr(A_LIM, 32'd1); wr(A_CNT, 32'd0);
    wr(A_CTRL, 32'h0000_0048);
    idle(4);
    #1 check("R8 irq high", {31'b0, irq}, 32'h1);
    @(negedge clk);
    wr(A_CTRL, 32'h0000_0040);
    rd(A_CTRL, d); check("R9 clear before read ignored", d, 32'h0000_00C0);
    wr(A_CTRL, 32'h0000_00C0);
    rd(A_CTRL, d); check("R9 write one ignored", d, 32'h0000_00C0);
    wr(A_CTRL, 32'h0000_0040);
    rd(A_CTRL, d); check("R9 armed clear", d, 32'h0000_0040);
    #1 check("R8 irq low after clear", {31'b0, irq}, 32'h0);
    @(negedge clk);
    wr(A_CTRL, 32'h0000_0008);
    idle(4);
    wr(A_CTRL, 32'h0000_0000);
    #1 check("R8 irq gated by enable", {31'b0, irq}, 32'h0);
    @(negedge clk);
    quiesce();

    // R10 overflow every clock collides with the clear
    wr(A_START, 32'd0); wr(A_LIM, 32'd0); wr(A_CNT, 32'd0);
    wr(A_CTRL, 32'h0000_0008);
    idle(2);
    rd(A_CTRL, d); check("R10 flag set", d, 32'h0000_0088);
    wr(A_CTRL, 32'h0000_0008);
    rd(A_CTRL, d); check("R10 set wins", d, 32'h0000_0088);
    quiesce();
    rd(A_CTRL, d); check("R9 final clear", d, 32'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule